// File: doc/BRIEF.md
# Reservation Station Pool with Result-Bus Wakeup

This block is a small pool of waiting slots for one class of functional unit in an out-of-order datapath. An operation enters through the issue port together with its two sources. Each source arrives either as a finished value or as the tag of the slot that will produce it. A slot holding a tag watches the shared result bus. When the tag on the bus equals the one it holds, the slot takes that value and drops the tag. Once both sources of a slot are values, the slot can be sent to the execution unit.

Each slot has a fixed result tag, equal to `BASE_TAG` plus its index. The execution unit later drives its result on the bus under that tag. That broadcast frees the slot for a new operation. When every slot is occupied, the pool raises `full` so that issue stalls.

Top module: `rs_pool`

## Requirements
- R1: After reset no slot is occupied, `full` is low and `dsp_valid` is low.
- R2: An accepted issue goes to the lowest-indexed free slot. Slot i carries result tag `BASE_TAG + i`, and that tag is presented on `dsp_tag` when the slot is dispatched.
- R3: `full` is high exactly when all `SLOTS` slots are occupied. An issue offered while `full` is high is dropped and never dispatched.
- R4: A source tag of 0 means the source value on the issue port is used directly. A non-zero source tag makes the slot wait for that producer.
- R5: A waiting source captures `bc_val` when `bc_valid` is high and `bc_tag` equals its tag. A slot is not dispatched until both of its sources hold values.
- R6: One broadcast wakes every matching source in the same cycle. This includes several slots, and both sources of one slot when they name the same tag.
- R7: If a source's producer broadcasts in the same cycle that source issues, the broadcast value is captured and the source does not wait.
- R8: At most one slot is dispatched per cycle. The lowest-indexed ready slot is chosen, and only on a clock edge where `ex_ready` is high.
- R9: A dispatch decided on a clock edge appears on `dsp_valid`, `dsp_op`, `dsp_a`, `dsp_b` and `dsp_tag` for one cycle after that edge. Each issued operation is dispatched exactly once.
- R10: A slot stays occupied after dispatch until its own result tag appears on the bus with `bc_valid` high. It is free for issue from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code |
| iss_a_tag | input | TAG_W | Producer tag of source A, 0 if the value is given |
| iss_a_val | input | DATA_W | Source A value |
| iss_b_tag | input | TAG_W | Producer tag of source B, 0 if the value is given |
| iss_b_val | input | DATA_W | Source B value |
| full | output | 1 | All slots occupied; issue stalls |
| bc_valid | input | 1 | Result bus valid |
| bc_tag | input | TAG_W | Result bus producer tag |
| bc_val | input | DATA_W | Result bus value |
| ex_ready | input | 1 | Execution unit can accept an operation |
| dsp_valid | output | 1 | Dispatch valid |
| dsp_op | output | OP_W | Dispatched operation code |
| dsp_a | output | DATA_W | Dispatched source A value |
| dsp_b | output | DATA_W | Dispatched source B value |
| dsp_tag | output | TAG_W | Result tag of the dispatched slot |

## Verification
The hardest case to reach from the ports is an issue and a matching broadcast landing on the same clock edge. The bench holds `bc_valid` and the producer tag on the bus during the issue cycle, then checks that the dispatched source carries the broadcast value.

A second hard case is one broadcast releasing several slots together. The bench first parks slots on shared tags, one of them naming the same tag in both sources, with the execution unit already ready. It then sends a single broadcast and checks that the released slots come out one per cycle in index order.

Finally, the bench fills the pool and keeps dispatched slots occupied. This lets it show that a dropped issue never appears and that only the slot's own result tag frees it.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Default sizes shared by the pool and its bench.
  localparam int RS_SLOTS  = 4;
  localparam int RS_TAG_W  = 3;
  localparam int RS_DATA_W = 16;
  localparam int RS_OP_W   = 4;

  // Result-bus hit for a waiting source; tag 0 never waits.
  function automatic logic bus_hit(input logic vld, input logic [RS_TAG_W-1:0] bus_tag,
                                   input logic [RS_TAG_W-1:0] want);
    return vld && (want != '0) && (bus_tag == want);
  endfunction
endpackage

// File: rtl/rs_first.sv
module rs_first #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_slot.sv
module rs_slot #(
  parameter int OP_W   = 4,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16,
  parameter int MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [OP_W-1:0]   ld_op,
  input  logic [TAG_W-1:0]  ld_qa,
  input  logic [DATA_W-1:0] ld_va,
  input  logic [TAG_W-1:0]  ld_qb,
  input  logic [DATA_W-1:0] ld_vb,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  input  logic              take,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] va,
  output logic [DATA_W-1:0] vb
);
  logic [TAG_W-1:0] qa, qb;
  logic             sent;
  logic             hit_a, hit_b, hit_ld_a, hit_ld_b, own_done;

  assign hit_a    = bc_valid && (qa != '0) && (bc_tag == qa);
  assign hit_b    = bc_valid && (qb != '0) && (bc_tag == qb);
  assign hit_ld_a = bc_valid && (ld_qa != '0) && (bc_tag == ld_qa);
  assign hit_ld_b = bc_valid && (ld_qb != '0) && (bc_tag == ld_qb);
  assign own_done = bc_valid && (bc_tag == TAG_W'(MY_TAG));
  assign ready    = busy && !sent && (qa == '0) && (qb == '0);

  // Control state with reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sent <= 1'b0;
      qa   <= '0;
      qb   <= '0;
    end else if (load) begin
      busy <= 1'b1;
      sent <= 1'b0;
      qa   <= hit_ld_a ? '0 : ld_qa;
      qb   <= hit_ld_b ? '0 : ld_qb;
    end else if (busy) begin
      if (hit_a) qa <= '0;
      if (hit_b) qb <= '0;
      if (take) sent <= 1'b1;
      if (own_done) busy <= 1'b0;
    end
  end

  // Payload without reset (plain storage).
  always_ff @(posedge clk) begin
    if (load) begin
      op <= ld_op;
      va <= hit_ld_a ? bc_val : ld_va;
      vb <= hit_ld_b ? bc_val : ld_vb;
    end else if (busy) begin
      if (hit_a) va <= bc_val;
      if (hit_b) vb <= bc_val;
    end
  end

  p_capture_a_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && !load && hit_a) |=> (qa == '0) && (va == $past(bc_val)));
  p_capture_b_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !load && hit_b) |=> (qb == '0) && (vb == $past(bc_val)));
  p_take_ready_r5: assert property (@(posedge clk) disable iff (rst)
    take |-> (busy && !sent && qa == '0 && qb == '0));
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !own_done) |=> busy);
  p_same_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    (load && hit_ld_a) |=> (qa == '0) && (va == $past(bc_val)));
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pkg::*;
#(
  parameter int SLOTS    = RS_SLOTS,
  parameter int TAG_W    = RS_TAG_W,
  parameter int DATA_W   = RS_DATA_W,
  parameter int OP_W     = RS_OP_W,
  parameter int BASE_TAG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic [DATA_W-1:0] iss_b_val,
  output logic              full,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  input  logic              ex_ready,
  output logic              dsp_valid,
  output logic [OP_W-1:0]   dsp_op,
  output logic [DATA_W-1:0] dsp_a,
  output logic [DATA_W-1:0] dsp_b,
  output logic [TAG_W-1:0]  dsp_tag
);
  logic [SLOTS-1:0] busy_v, ready_v, free_g, rdy_g, load_v, take_v;
  logic [OP_W-1:0]   s_op [SLOTS];
  logic [DATA_W-1:0] s_va [SLOTS];
  logic [DATA_W-1:0] s_vb [SLOTS];

  assign full = &busy_v;

  rs_first #(.N(SLOTS)) u_free_pick (.req(~busy_v), .gnt(free_g));
  rs_first #(.N(SLOTS)) u_rdy_pick  (.req(ready_v), .gnt(rdy_g));

  assign load_v = (iss_valid && !full) ? free_g : '0;
  assign take_v = ex_ready ? rdy_g : '0;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    rs_slot #(
      .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .MY_TAG(BASE_TAG + g)
    ) u_slot (
      .clk(clk), .rst(rst), .load(load_v[g]),
      .ld_op(iss_op), .ld_qa(iss_a_tag), .ld_va(iss_a_val),
      .ld_qb(iss_b_tag), .ld_vb(iss_b_val),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .take(take_v[g]), .busy(busy_v[g]), .ready(ready_v[g]),
      .op(s_op[g]), .va(s_va[g]), .vb(s_vb[g])
    );
  end

  // One-hot mux of the chosen slot.
  logic [OP_W-1:0]   n_op;
  logic [DATA_W-1:0] n_a, n_b;
  logic [TAG_W-1:0]  n_tag;
  always_comb begin
    n_op  = '0;
    n_a   = '0;
    n_b   = '0;
    n_tag = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (take_v[i]) begin
        n_op  = n_op  | s_op[i];
        n_a   = n_a   | s_va[i];
        n_b   = n_b   | s_vb[i];
        n_tag = n_tag | TAG_W'(BASE_TAG + i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dsp_valid <= 1'b0;
    else     dsp_valid <= |take_v;
  end

  always_ff @(posedge clk) begin
    dsp_op  <= n_op;
    dsp_a   <= n_a;
    dsp_b   <= n_b;
    dsp_tag <= n_tag;
  end

  p_one_take_r8: assert property (@(posedge clk) disable iff (rst) $onehot0(take_v));
  p_dsp_gated_r8: assert property (@(posedge clk) disable iff (rst)
    dsp_valid |-> $past(ex_ready));
  p_full_stuck_r3: assert property (@(posedge clk) disable iff (rst)
    (full && !bc_valid) |=> full);
  p_no_load_full_r3: assert property (@(posedge clk) disable iff (rst)
    full |-> (load_v == '0));
endmodule

// File: tb/rs_pool_tb.sv
module rs_pool_tb_top;
  localparam int CLK_P = 10;
  localparam int TW = 3, DW = 16, OW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic iss_valid = 0, bc_valid = 0, ex_ready = 0;
  logic [OW-1:0] iss_op = '0;
  logic [TW-1:0] iss_a_tag = '0, iss_b_tag = '0, bc_tag = '0;
  logic [DW-1:0] iss_a_val = '0, iss_b_val = '0, bc_val = '0;
  logic full, dsp_valid;
  logic [OW-1:0] dsp_op;
  logic [DW-1:0] dsp_a, dsp_b;
  logic [TW-1:0] dsp_tag;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  rs_pool #(.SLOTS(4), .TAG_W(TW), .DATA_W(DW), .OP_W(OW), .BASE_TAG(1)) dut_i (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val), .iss_b_tag(iss_b_tag),
    .iss_b_val(iss_b_val), .full(full), .bc_valid(bc_valid), .bc_tag(bc_tag),
    .bc_val(bc_val), .ex_ready(ex_ready), .dsp_valid(dsp_valid), .dsp_op(dsp_op),
    .dsp_a(dsp_a), .dsp_b(dsp_b), .dsp_tag(dsp_tag));

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(int op, int qa, int va, int qb, int vb);
    iss_valid = 1; iss_op = OW'(op);
    iss_a_tag = TW'(qa); iss_a_val = DW'(va);
    iss_b_tag = TW'(qb); iss_b_val = DW'(vb);
    tick();
    iss_valid = 0;
  endtask

  task automatic bcast(int tg, int v);
    bc_valid = 1; bc_tag = TW'(tg); bc_val = DW'(v);
    tick();
    bc_valid = 0;
  endtask

  task automatic expect_dsp(string rq, int tg, int op, int a, int b);
    chk(rq, dsp_valid, 1);
    chk(rq, dsp_tag, tg);
    chk(rq, dsp_op, op);
    chk(rq, dsp_a, a);
    chk(rq, dsp_b, b);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
        finish_run();
      end
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 full", full, 0);
    chk("R1 dsp_valid", dsp_valid, 0);

    // R2/R3/R4/R8/R9: fill with ready ops, hold unit off
    ex_ready = 0;
    for (int i = 0; i < 4; i++) begin
      chk("R3 full before fill", full, 0);
      issue(i, 0, 10 + i, 0, 20 + i);
    end
    chk("R3 full", full, 1);
    issue(15, 0, 99, 0, 99);           // dropped (R3)
    chk("R8 no dispatch without ex_ready", dsp_valid, 0);
    ex_ready = 1;
    for (int i = 0; i < 4; i++) begin
      tick();
      expect_dsp("R2 R8 R9 order", i + 1, i, 10 + i, 20 + i);
    end
    tick();
    chk("R3 R9 dropped op never dispatched", dsp_valid, 0);
    chk("R10 full held after dispatch", full, 1);
    bcast(1, 0);
    chk("R10 free on own tag", full, 0);
    for (int t = 2; t <= 4; t++) bcast(t, 0);

    // R4/R5/R6 dependency wakeup, unit ready
    issue(3, 5, 0, 0, 7);       // slot0 waits on 5
    issue(4, 6, 0, 6, 0);       // slot1 waits on 6 twice
    issue(5, 5, 0, 0, 3);       // slot2 waits on 5
    tick();
    chk("R4 R5 waiting slots not dispatched", dsp_valid, 0);
    bcast(5, 100);
    chk("R5 no dispatch on wake edge", dsp_valid, 0);
    tick();
    expect_dsp("R6 first woken", 1, 3, 100, 7);
    tick();
    expect_dsp("R6 second woken", 3, 5, 100, 3);
    tick();
    chk("R5 slot1 still waiting", dsp_valid, 0);
    bcast(6, 55);
    tick();
    expect_dsp("R6 both sources same tag", 2, 4, 55, 55);
    for (int t = 1; t <= 3; t++) bcast(t, 0);

    // R7 same-cycle issue and broadcast
    bc_valid = 1; bc_tag = 3'd7; bc_val = 16'h1234;
    issue(6, 7, 0, 0, 9);
    bc_valid = 0;
    tick();
    expect_dsp("R7 same-cycle capture", 1, 6, 16'h1234, 9);
    bcast(1, 0);

    // R8 ex_ready gating
    ex_ready = 0;
    issue(2, 0, 40, 0, 41);
    tick(); tick();
    chk("R8 held while ex_ready low", dsp_valid, 0);
    ex_ready = 1;
    tick();
    expect_dsp("R8 released", 1, 2, 40, 41);
    bcast(1, 0);

    // R10 busy until own tag, R2 lowest free reuse
    for (int i = 0; i < 4; i++) issue(8 + i, 0, i, 0, i);
    tick(); tick(); tick();
    chk("R10 full after all dispatched", full, 1);
    bcast(6, 1);
    chk("R10 foreign tag keeps busy", full, 1);
    bcast(3, 1);
    chk("R10 own tag frees", full, 0);
    issue(13, 0, 77, 0, 78);
    tick();
    expect_dsp("R2 reuse lowest free slot", 3, 13, 77, 78);
    for (int t = 1; t <= 4; t++) bcast(t, 0);
    chk("R10 all freed", full, 0);

    finish_run();
  end
endmodule